// File: doc/BRIEF.md
# Randomized S-Box Configuration Selector

This block chooses which of 32 precomputed parameter sets an S-box bank uses to compute its substitution. It also chooses two decoy back-mapping matrices that run beside the real final stage. Every set yields the same substitution result, but each set switches different internal nodes. Drawing a fresh set for every cipher block therefore weakens the link between the processed data and the supply current. A 16-bit LFSR supplies the active set index. A second 16-bit LFSR supplies the two decoy matrix indices.

Both generators are seeded through one load port. An encryptor and a decryptor that load the same seed step through the same index sequence, in the same way that they share the key. The cipher pulses a strobe at the start of each block. The three indices change only in the cycle after that strobe and then hold steady. All three outputs come straight from flops, so the selector adds no gates to the S-box's timing path.

Top module: `sbox_cfg_sel`

## Requirements
- R1: While rst_n is low and after reset, cfgIdx is 0, decoyIdxA is 1 and decoyIdxB is 2.
- R2: When seedLoad is high, the primary LFSR takes seedVal at the clock edge, or 16'h0001 if seedVal is zero. The three index outputs do not change in that cycle.
- R3: The same load puts seedVal XOR 16'hACE1 into the secondary LFSR, or 16'h0001 if that value is zero.
- R4: When blockStart is high and seedLoad is low (a draw), cfgIdx takes bits [4:0] of the primary LFSR state at the clock edge. Both LFSRs then step once: shift left, with bit 0 taking the XOR of bits 15, 13, 12 and 10 (taps 16, 14, 13, 11).
- R5: Between draws, cfgIdx, decoyIdxA and decoyIdxB keep their values.
- R6: On a draw, decoyIdxA takes bits [4:0] of the pre-step secondary state. If that value equals the new cfgIdx, it takes that value plus 1, modulo 32.
- R7: On a draw, decoyIdxB starts from bits [9:5] of the pre-step secondary state. The check runs twice: each time the candidate equals the new cfgIdx or the new decoyIdxA, it is incremented by 1, modulo 32.
- R8: cfgIdx, decoyIdxA and decoyIdxB are pairwise different at all times.
- R9: seedLoad takes priority over blockStart. A cycle with both high only loads the seed.
- R10: Loading the same seed again reproduces the same sequence of index triples over the following draws.
- R11: The outputs depend only on flops. A change on an input between clock edges leaves them unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seedLoad | input | 1 | Load both generators from seedVal |
| seedVal | input | 16 | Shared seed value |
| blockStart | input | 1 | Start of cipher block; draws new indices |
| cfgIdx | output | 5 | Active S-box parameter set index |
| decoyIdxA | output | 5 | First decoy back-map matrix index |
| decoyIdxB | output | 5 | Second decoy back-map matrix index |

## Verification
The bench builds the block with its default parameters: 16-bit generators, taps 16/14/13/11 and 5-bit indices. With 5-bit indices, random draws run into collisions between the decoy candidates and the active index often enough to exercise both the single and the double increment, including wrap past 31. Directed seeds of zero and of the XOR constant check the replacement of a zero state. Strobes held across long idle gaps and strobes raised together with a load check stability and priority. A second load of the same seed, followed by the same draws, checks reproducibility.

// File: rtl/sbox_sel_pkg.sv
package sbox_sel_pkg;

  typedef struct packed {
    logic load;
    logic draw;
  } selStrobe_t;

endpackage

// File: rtl/sbox_sel_lfsr.sv
module sbox_sel_lfsr #(
  parameter int W = 16,
  parameter logic [W-1:0] TAP_MASK = 16'hB400,
  parameter int OUT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [W-1:0]     loadVal,
  input  logic             step,
  output logic [OUT_W-1:0] low
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] state;
  logic         feedBit;

  assign feedBit = ^(state & TAP_MASK);
  assign low     = state[OUT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ONE;
    end else if (load) begin
      state <= (loadVal == '0) ? ONE : loadVal;
    end else if (step) begin
      state <= {state[W-2:0], feedBit};
    end
  end
endmodule

// File: rtl/sbox_sel_ctrl.sv
module sbox_sel_ctrl
  import sbox_sel_pkg::*;
(
  input  logic       seedLoad,
  input  logic       blockStart,
  output selStrobe_t strobe
);
  always_comb begin
    strobe.load = seedLoad;
    strobe.draw = blockStart && !seedLoad;
  end
endmodule

// File: rtl/sbox_sel_dp.sv
module sbox_sel_dp
  import sbox_sel_pkg::*;
#(
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] TAP_MASK = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED_XOR = 16'hACE1,
  parameter int IDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  selStrobe_t        strobe,
  input  logic [LFSR_W-1:0] seedVal,
  output logic [IDX_W-1:0]  cfgIdx,
  output logic [IDX_W-1:0]  decoyIdxA,
  output logic [IDX_W-1:0]  decoyIdxB
);
  localparam int B_OUT_W = 2 * IDX_W;
  localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_TWO = IDX_W'(2);

  logic [IDX_W-1:0]   lowA;
  logic [B_OUT_W-1:0] lowB;

  sbox_sel_lfsr #(.W(LFSR_W), .TAP_MASK(TAP_MASK), .OUT_W(IDX_W)) u_lfsrA (
    .clk(clk), .rst_n(rst_n), .load(strobe.load), .loadVal(seedVal),
    .step(strobe.draw), .low(lowA)
  );

  sbox_sel_lfsr #(.W(LFSR_W), .TAP_MASK(TAP_MASK), .OUT_W(B_OUT_W)) u_lfsrB (
    .clk(clk), .rst_n(rst_n), .load(strobe.load), .loadVal(seedVal ^ SEED_XOR),
    .step(strobe.draw), .low(lowB)
  );

  logic [IDX_W-1:0] nextA, candB, bumpB1, nextB;

  always_comb begin
    nextA  = (lowB[IDX_W-1:0] == lowA) ? lowB[IDX_W-1:0] + IDX_ONE : lowB[IDX_W-1:0];
    candB  = lowB[B_OUT_W-1:IDX_W];
    bumpB1 = (candB == lowA || candB == nextA) ? candB + IDX_ONE : candB;
    nextB  = (bumpB1 == lowA || bumpB1 == nextA) ? bumpB1 + IDX_ONE : bumpB1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfgIdx    <= '0;
      decoyIdxA <= IDX_ONE;
      decoyIdxB <= IDX_TWO;
    end else if (strobe.draw) begin
      cfgIdx    <= lowA;
      decoyIdxA <= nextA;
      decoyIdxB <= nextB;
    end
  end
endmodule

// File: rtl/sbox_cfg_sel.sv
module sbox_cfg_sel
  import sbox_sel_pkg::*;
#(
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] TAP_MASK = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED_XOR = 16'hACE1,
  parameter int IDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seedLoad,
  input  logic [LFSR_W-1:0] seedVal,
  input  logic              blockStart,
  output logic [IDX_W-1:0]  cfgIdx,
  output logic [IDX_W-1:0]  decoyIdxA,
  output logic [IDX_W-1:0]  decoyIdxB
);
  selStrobe_t strobe;

  sbox_sel_ctrl u_ctrl (
    .seedLoad(seedLoad), .blockStart(blockStart), .strobe(strobe)
  );

  sbox_sel_dp #(
    .LFSR_W(LFSR_W), .TAP_MASK(TAP_MASK), .SEED_XOR(SEED_XOR), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .seedVal(seedVal),
    .cfgIdx(cfgIdx), .decoyIdxA(decoyIdxA), .decoyIdxB(decoyIdxB)
  );
endmodule

// File: rtl/sbox_cfg_sel_chk.sv
module sbox_cfg_sel_chk #(
  parameter int LFSR_W = 16,
  parameter int IDX_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              seedLoad,
  input logic [LFSR_W-1:0] seedVal,
  input logic              blockStart,
  input logic [IDX_W-1:0]  cfgIdx,
  input logic [IDX_W-1:0]  decoyIdxA,
  input logic [IDX_W-1:0]  decoyIdxB,
  input logic [IDX_W-1:0]  lowA
);
  AST_HOLD_BETWEEN_DRAWS: assert property (@(posedge clk) disable iff (!rst_n)
    !(blockStart && !seedLoad) |=> $stable({cfgIdx, decoyIdxA, decoyIdxB})); // R5

  AST_INDICES_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgIdx != decoyIdxA) && (cfgIdx != decoyIdxB) && (decoyIdxA != decoyIdxB)); // R8

  AST_ZERO_SEED_FIX: assert property (@(posedge clk) disable iff (!rst_n)
    seedLoad && (seedVal == '0) ##1 (blockStart && !seedLoad) |=> (cfgIdx == IDX_W'(1))); // R2

  AST_CFG_FROM_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    blockStart && !seedLoad |=> cfgIdx == $past(lowA)); // R4

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    seedLoad && blockStart |=> $stable(cfgIdx)); // R9
endmodule

bind sbox_cfg_sel sbox_cfg_sel_chk #(.LFSR_W(LFSR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .seedLoad(seedLoad), .seedVal(seedVal),
  .blockStart(blockStart), .cfgIdx(cfgIdx), .decoyIdxA(decoyIdxA),
  .decoyIdxB(decoyIdxB), .lowA(u_dp.lowA)
);

// File: tb/sbox_cfg_sel_tb.sv
module sbox_cfg_sel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seedLoad = 1'b0;
  logic [15:0] seedVal = '0;
  logic        blockStart = 1'b0;
  logic [4:0]  cfgIdx, decoyIdxA, decoyIdxB;

  int checks = 0;
  int errors = 0;

  logic [15:0] mA, mB;
  logic [4:0]  mC, mDA, mDB;

  always #2.5 clk = ~clk;

  sbox_cfg_sel u_dut (
    .clk(clk), .rst_n(rst_n), .seedLoad(seedLoad), .seedVal(seedVal),
    .blockStart(blockStart), .cfgIdx(cfgIdx), .decoyIdxA(decoyIdxA),
    .decoyIdxB(decoyIdxB)
  );

  function automatic logic [15:0] stepState(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [15:0] fixZero(input logic [15:0] s);
    return (s == 16'h0) ? 16'h1 : s;
  endfunction

  task automatic check(input string req, input logic [14:0] got, input logic [14:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic modelEdge(input logic ld, input logic [15:0] sv, input logic bs);
    logic [4:0] a, b;
    if (ld) begin
      mA = fixZero(sv);
      mB = fixZero(sv ^ 16'hACE1);
    end else if (bs) begin
      mC = mA[4:0];
      a = mB[4:0];
      if (a == mC) a = a + 5'd1;
      b = mB[9:5];
      if (b == mC || b == a) b = b + 5'd1;
      if (b == mC || b == a) b = b + 5'd1;
      mDA = a;
      mDB = b;
      mA = stepState(mA);
      mB = stepState(mB);
    end
  endtask

  task automatic cyc(input logic ld, input logic [15:0] sv, input logic bs, input string req);
    @(negedge clk);
    seedLoad = ld; seedVal = sv; blockStart = bs;
    #1;
    check("R11", {cfgIdx, decoyIdxA, decoyIdxB}, {mC, mDA, mDB});
    @(posedge clk);
    modelEdge(ld, sv, bs);
    #1;
    check(req, {cfgIdx, decoyIdxA, decoyIdxB}, {mC, mDA, mDB});
    if (cfgIdx == decoyIdxA || cfgIdx == decoyIdxB || decoyIdxA == decoyIdxB)
      check("R8", 15'd1, 15'd0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [14:0] rec [8];
    void'($urandom(32'd5150));
    mA = 16'h1; mB = 16'h1; mC = 5'd0; mDA = 5'd1; mDB = 5'd2;
    repeat (3) @(posedge clk);
    #1;
    check("R1", {cfgIdx, decoyIdxA, decoyIdxB}, {5'd0, 5'd1, 5'd2});
    @(negedge clk);
    rst_n = 1'b1;

    // R2: load then draw exposes seed[4:0]
    cyc(1'b1, 16'h3C5A, 1'b0, "R2");
    cyc(1'b0, 16'h0, 1'b1, "R4");
    check("R2", {10'd0, cfgIdx}, {10'd0, 5'h1A});
    // R2 zero seed
    cyc(1'b1, 16'h0, 1'b0, "R2");
    cyc(1'b0, 16'h0, 1'b1, "R2");
    check("R2", {10'd0, cfgIdx}, 15'd1);
    // R3: secondary becomes zero -> 1
    cyc(1'b1, 16'hACE1, 1'b0, "R3");
    cyc(1'b0, 16'h0, 1'b1, "R3");
    // R9: load and strobe together
    cyc(1'b1, 16'h1234, 1'b1, "R9");
    cyc(1'b0, 16'h0, 1'b1, "R6");
    cyc(1'b0, 16'h0, 1'b1, "R7");
    // R5: idle cycles
    repeat (6) cyc(1'b0, 16'hFFFF, 1'b0, "R5");

    // R10: reproducibility
    cyc(1'b1, 16'hBEEF, 1'b0, "R10");
    for (int i = 0; i < 8; i++) begin
      cyc(1'b0, 16'h0, 1'b1, "R10");
      rec[i] = {cfgIdx, decoyIdxA, decoyIdxB};
    end
    cyc(1'b0, 16'h0, 1'b0, "R5");
    cyc(1'b1, 16'hBEEF, 1'b0, "R10");
    for (int i = 0; i < 8; i++) begin
      cyc(1'b0, 16'h0, 1'b1, "R10");
      check("R10", {cfgIdx, decoyIdxA, decoyIdxB}, rec[i]);
    end

    // random mix: R4 R5 R6 R7 R9
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom_range(0, 99);
      cyc(r < 4, 16'($urandom), r >= 2 && r < 55, "R6_R7");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule